// File: doc/BRIEF.md
# Compare-Immediate Bus Cycle Sequencer

This block produces the bus traffic of a compare-immediate instruction on a CPU with a 16-bit data bus. The instruction starts with two words already in the prefetch queue. One start pulse latches the operand size, the effective-address mode, the program counter and the operand address. The sequencer then issues its prefetch cycles, data read cycles and idle internal slots in a fixed order and with a fixed length for each.

The order is set by the size and the mode:

1. The immediate data is prefetched first.
2. Any address-extension words are prefetched next. Some modes insert an idle slot first.
3. The operand is read.
4. One final prefetch closes the instruction.

The first word of the following instruction is therefore fetched before the operand read and the second word after it, so the bus order does not follow program order. A simple acknowledge input can stretch any bus cycle without changing the order of the cycles.

Top module: `cmpi_bus_seq`

## Requirements
- R1: `size_i` encodes 0 = byte, 1 = word, 2 = long. `mode_i` encodes 0 = data register, 1 = indirect, 2 = postincrement, 3 = predecrement, 4 = 16-bit displacement, 5 = indexed, 6 = absolute short, 7 = absolute long. All inputs are latched on the accepted start.
- R2: Every prefetch cycle drives `bus_read_o` = 0. The first prefetch address is the latched `pc_i` + 4, and each later prefetch is 2 higher than the one before it.
- R3: The sequence opens with the immediate-data prefetches: one for byte and word, two for long.
- R4: The data reads drive `bus_read_o` = 1. Long size reads at the operand address and then at the operand address + 2. Byte and word read once at the operand address. Mode 0 makes no data read.
- R5: After the reads comes exactly one prefetch. In long size with mode 0, an idle slot follows that prefetch and ends the sequence.
- R6: Between the immediate prefetches and the reads, the extra steps depend on the mode:
  - Modes 3 and 5 insert one idle slot.
  - Modes 4, 5 and 6 then add one prefetch.
  - Mode 7 adds two prefetches.
- R7: A bus cycle lasts 4 clocks. The address and kind are valid in all 4 clocks, and `bus_strobe_o` is high in the last 3. Each clock in which `bus_ack_i` is low in the final clock extends the cycle by one clock.
- R8: An idle slot lasts 2 clocks. During it `idle_o` is high and `bus_strobe_o` is low.
- R9: With immediate acknowledge, the sequence length is:
  - Long: 14, 20, 20, 22, 24, 26, 24 and 28 clocks for modes 0 to 7.
  - Byte and word: 8, 12, 12, 14, 16, 18, 16 and 20 clocks.
- R10: `done_o` is high for exactly one clock, in the clock right after the last clock of the last slot.
- R11: A start that arrives while a sequence is running is ignored, and the running sequence is unchanged.
- R12: After reset, `bus_strobe_o`, `idle_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| size_i | input | 2 | Operand size |
| mode_i | input | 3 | Effective-address mode |
| pc_i | input | AW | Address of the opcode word |
| ea_addr_i | input | AW | Operand address |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_addr_o | output | AW | Bus cycle address |
| bus_read_o | output | 1 | 1 = data read, 0 = program prefetch |
| bus_strobe_o | output | 1 | Bus strobe |
| idle_o | output | 1 | Idle internal slot in progress |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The assertions check the following on every cycle:
- the strobe and the idle flag are never high together;
- the idle slot is two clocks long;
- the address and kind hold steady while the strobe is up;
- a bus cycle that lacks an acknowledge keeps its strobe;
- `done_o` is a single clock wide and falls in a clock with no slot.

The order of the cycles, their addresses and the total clock count for each of the 24 size and mode pairs can be shown only by the bench's sweep. The same holds for the stretching by wait clocks and for the start pulse that is ignored while the sequence runs. The bench computes each expected list from the per-mode step counts.

// File: rtl/cmpi_seq_pkg.sv
package cmpi_seq_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_IMM   = 3'd1,
    PH_PRE   = 3'd2,
    PH_EXT   = 3'd3,
    PH_READ  = 3'd4,
    PH_FINAL = 3'd5,
    PH_POST  = 3'd6
  } phase_e;

  localparam int unsigned NUM_PH = 7;

  typedef enum logic [2:0] {
    EA_DREG    = 3'd0,
    EA_IND     = 3'd1,
    EA_POSTINC = 3'd2,
    EA_PREDEC  = 3'd3,
    EA_DISP    = 3'd4,
    EA_INDEX   = 3'd5,
    EA_ABSW    = 3'd6,
    EA_ABSL    = 3'd7
  } ea_mode_e;

  // slot counts per phase
  typedef struct packed {
    logic [1:0] imm;
    logic [1:0] pre;
    logic [1:0] ext;
    logic [1:0] rd;
    logic [1:0] fin;
    logic [1:0] post;
  } plan_t;

  function automatic logic [1:0] phase_count(phase_e ph, plan_t pl);
    logic [1:0] c;
    unique case (ph)
      PH_IMM:   c = pl.imm;
      PH_PRE:   c = pl.pre;
      PH_EXT:   c = pl.ext;
      PH_READ:  c = pl.rd;
      PH_FINAL: c = pl.fin;
      PH_POST:  c = pl.post;
      default:  c = 2'd0;
    endcase
    return c;
  endfunction

  function automatic logic is_idle_phase(phase_e ph);
    return (ph == PH_PRE) || (ph == PH_POST);
  endfunction

endpackage

// File: rtl/cmpi_step_plan.sv
module cmpi_step_plan
  import cmpi_seq_pkg::*;
(
  input  logic     long_i,
  input  ea_mode_e mode_i,
  output plan_t    plan_o
);

  always_comb begin
    plan_o      = '0;
    plan_o.imm  = long_i ? 2'd2 : 2'd1;
    plan_o.fin  = 2'd1;
    plan_o.rd   = (mode_i == EA_DREG) ? 2'd0 : (long_i ? 2'd2 : 2'd1);
    plan_o.pre  = (mode_i == EA_PREDEC || mode_i == EA_INDEX) ? 2'd1 : 2'd0;
    plan_o.post = (long_i && mode_i == EA_DREG) ? 2'd1 : 2'd0;
    unique case (mode_i)
      EA_DISP, EA_INDEX, EA_ABSW: plan_o.ext = 2'd1;
      EA_ABSL:                    plan_o.ext = 2'd2;
      default:                    plan_o.ext = 2'd0;
    endcase
  end

endmodule

// File: rtl/cmpi_step_seq.sv
module cmpi_step_seq
  import cmpi_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  plan_t  plan_i,
  input  logic   slot_end_i,
  output logic   busy_o,
  output phase_e phase_o,
  output logic   done_o
);

  phase_e     phase_q;
  logic [1:0] left_q;
  plan_t      plan_q;
  logic       done_q;
  phase_e     nxt;

  assign busy_o  = (phase_q != PH_NONE);
  assign phase_o = phase_q;
  assign done_o  = done_q;

  // lowest later phase with a nonzero count
  always_comb begin
    nxt = PH_NONE;
    for (int i = NUM_PH - 1; i >= 1; i--) begin
      if (i > int'(phase_q) && phase_count(phase_e'(i[2:0]), plan_q) != 2'd0)
        nxt = phase_e'(i[2:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_NONE;
      left_q  <= '0;
      plan_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          plan_q  <= plan_i;
          phase_q <= PH_IMM;
          left_q  <= plan_i.imm;
        end
      end else if (slot_end_i) begin
        if (left_q > 2'd1) begin
          left_q <= left_q - 2'd1;
        end else if (nxt != PH_NONE) begin
          phase_q <= nxt;
          left_q  <= phase_count(nxt, plan_q);
        end else begin
          phase_q <= PH_NONE;
          done_q  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cmpi_slot_timer.sv
module cmpi_slot_timer #(
  parameter int unsigned BUS_CLKS  = 4,
  parameter int unsigned IDLE_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic idle_slot_i,
  input  logic ack_i,
  output logic slot_end_o,
  output logic strobe_o,
  output logic idle_o
);

  localparam int unsigned MAXC = (BUS_CLKS > IDLE_CLKS) ? BUS_CLKS : IDLE_CLKS;
  localparam int unsigned CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] BUS_LAST  = CW'(BUS_CLKS - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last    = idle_slot_i ? (cnt_q == IDLE_LAST) : (cnt_q == BUS_LAST);
  assign slot_end_o = busy_i && at_last && (idle_slot_i || ack_i);
  assign strobe_o   = busy_i && !idle_slot_i && (cnt_q != '0);
  assign idle_o     = busy_i && idle_slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!busy_i || slot_end_o) cnt_q <= '0;
    else if (!at_last)              cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/cmpi_addr_gen.sv
module cmpi_addr_gen
  import cmpi_seq_pkg::*;
#(
  parameter int unsigned AW      = 24,
  parameter int unsigned PF_LEAD = 4,
  parameter int unsigned WORD_B  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ea_i,
  input  logic          slot_end_i,
  input  phase_e        phase_i,
  output logic [AW-1:0] addr_o,
  output logic          read_o
);

  localparam logic [AW-1:0] LEAD = AW'(PF_LEAD);
  localparam logic [AW-1:0] STEP = AW'(WORD_B);

  logic [AW-1:0] pf_q, ea_q, off_q;
  logic          is_rd, is_pf;

  assign is_rd  = (phase_i == PH_READ);
  assign is_pf  = (phase_i == PH_IMM) || (phase_i == PH_EXT) || (phase_i == PH_FINAL);
  assign read_o = is_rd;
  assign addr_o = is_rd ? (ea_q + off_q) : pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q  <= '0;
      ea_q  <= '0;
      off_q <= '0;
    end else if (load_i) begin
      pf_q  <= pc_i + LEAD;
      ea_q  <= ea_i;
      off_q <= '0;
    end else if (slot_end_i) begin
      if (is_pf) pf_q  <= pf_q + STEP;
      if (is_rd) off_q <= off_q + STEP;
    end
  end

endmodule

// File: rtl/cmpi_bus_seq.sv
module cmpi_bus_seq
  import cmpi_seq_pkg::*;
#(
  parameter int unsigned AW        = 24,
  parameter int unsigned BUS_CLKS  = 4,
  parameter int unsigned IDLE_CLKS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ea_addr_i,
  input  logic          bus_ack_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_read_o,
  output logic          bus_strobe_o,
  output logic          idle_o,
  output logic          done_o
);

  plan_t  plan;
  phase_e phase;
  logic   busy, slot_end, start_acc;

  assign start_acc = start_i && !busy;

  cmpi_step_plan u_plan (
    .long_i (size_i[1]),
    .mode_i (ea_mode_e'(mode_i)),
    .plan_o (plan)
  );

  cmpi_step_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .plan_i     (plan),
    .slot_end_i (slot_end),
    .busy_o     (busy),
    .phase_o    (phase),
    .done_o     (done_o)
  );

  cmpi_slot_timer #(
    .BUS_CLKS  (BUS_CLKS),
    .IDLE_CLKS (IDLE_CLKS)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .idle_slot_i (is_idle_phase(phase)),
    .ack_i       (bus_ack_i),
    .slot_end_o  (slot_end),
    .strobe_o    (bus_strobe_o),
    .idle_o      (idle_o)
  );

  cmpi_addr_gen #(
    .AW (AW)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_acc),
    .pc_i       (pc_i),
    .ea_i       (ea_addr_i),
    .slot_end_i (slot_end),
    .phase_i    (phase),
    .addr_o     (bus_addr_o),
    .read_o     (bus_read_o)
  );

endmodule

// File: rtl/cmpi_bus_seq_chk.sv
module cmpi_bus_seq_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_ack_i,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_read_o,
  input logic          bus_strobe_o,
  input logic          idle_o,
  input logic          done_o
);

  p_strobe_idle_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_strobe_o && idle_o));

  p_idle_two_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |=> idle_o);

  p_idle_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && $past(idle_o)) |=> !idle_o);

  p_cycle_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_strobe_o && $past(bus_strobe_o)) |-> ($stable(bus_addr_o) && $stable(bus_read_o)));

  p_wait_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_strobe_o && $past(bus_strobe_o) && $past(bus_strobe_o, 2) && !bus_ack_i) |=> bus_strobe_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!bus_strobe_o && !idle_o));

endmodule

bind cmpi_bus_seq cmpi_bus_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_ack_i    (bus_ack_i),
  .bus_addr_o   (bus_addr_o),
  .bus_read_o   (bus_read_o),
  .bus_strobe_o (bus_strobe_o),
  .idle_o       (idle_o),
  .done_o       (done_o)
);

// File: tb/cmpi_bus_seq_test.sv
module cmpi_bus_seq_test;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    size = '0;
  logic [2:0]    mode = '0;
  logic [AW-1:0] pc_in = '0;
  logic [AW-1:0] ea_in = '0;
  logic          ack = 1'b1;
  logic [AW-1:0] bus_addr;
  logic          bus_read, bus_strobe, idle, done;

  int checks = 0;
  int fails = 0;

  // entry kinds: 0 prefetch, 1 data read, 2 idle
  int          exp_k[16];
  logic [AW-1:0] exp_a[16];
  int          exp_n;
  int          act_k[16];
  logic [AW-1:0] act_a[16];
  int          act_n = 0;
  int          wait_cfg = 0;
  int          sc = 0;
  logic        prev_stb = 1'b0, prev_idle = 1'b0;

  always #10 clk = ~clk;

  cmpi_bus_seq #(.AW(AW)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .size_i       (size),
    .mode_i       (mode),
    .pc_i         (pc_in),
    .ea_addr_i    (ea_in),
    .bus_ack_i    (ack),
    .bus_addr_o   (bus_addr),
    .bus_read_o   (bus_read),
    .bus_strobe_o (bus_strobe),
    .idle_o       (idle),
    .done_o       (done)
  );

  // recorder and acknowledge model
  always @(negedge clk) begin
    if (bus_strobe && !prev_stb) begin
      if (act_n < 16) begin
        act_k[act_n] = bus_read ? 1 : 0;
        act_a[act_n] = bus_addr;
      end
      act_n = act_n + 1;
      sc = 1;
    end else if (bus_strobe) begin
      sc = sc + 1;
    end
    if (idle && !prev_idle) begin
      if (act_n < 16) begin
        act_k[act_n] = 2;
        act_a[act_n] = '0;
      end
      act_n = act_n + 1;
    end
    ack = (sc >= 3 + wait_cfg);
    prev_stb = bus_strobe;
    prev_idle = idle;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [AW-1:0] a);
    exp_k[exp_n] = k;
    exp_a[exp_n] = a;
    exp_n++;
  endtask

  // build the expected list from the R3..R6 step rules
  task automatic build_exp(input logic [1:0] sz, input logic [2:0] md,
                           input logic [AW-1:0] pc, input logic [AW-1:0] ea);
    bit lng;
    int n_imm, n_ext, n_rd;
    logic [AW-1:0] pf;
    lng   = (sz == 2'd2);
    n_imm = lng ? 2 : 1;
    n_ext = (md == 3'd4 || md == 3'd5 || md == 3'd6) ? 1 : (md == 3'd7 ? 2 : 0);
    n_rd  = (md == 3'd0) ? 0 : (lng ? 2 : 1);
    exp_n = 0;
    pf    = pc + 24'd4;
    for (int i = 0; i < n_imm; i++) begin push(0, pf); pf = pf + 24'd2; end
    if (md == 3'd3 || md == 3'd5) push(2, '0);
    for (int i = 0; i < n_ext; i++) begin push(0, pf); pf = pf + 24'd2; end
    for (int i = 0; i < n_rd; i++) push(1, ea + 24'(2 * i));
    push(0, pf);
    if (lng && md == 3'd0) push(2, '0);
  endtask

  function automatic int table_clocks(input logic [1:0] sz, input logic [2:0] md);
    int lt[8] = '{14, 20, 20, 22, 24, 26, 24, 28};
    int bt[8] = '{8, 12, 12, 14, 16, 18, 16, 20};
    return (sz == 2'd2) ? lt[md] : bt[md];
  endfunction

  task automatic run_case(input logic [1:0] sz, input logic [2:0] md, input int w, input bit inj);
    int cnt, nbus, nidle, exp_clk, bad;
    logic [AW-1:0] pc, ea;
    pc = 24'hFC0036 + 24'(int'(sz) * 256 + int'(md) * 32);
    ea = 24'hFA0000 + 24'(int'(sz) * 4096 + int'(md) * 64);
    build_exp(sz, md, pc, ea);
    @(negedge clk);
    wait_cfg = w;
    size = sz; mode = md; pc_in = pc; ea_in = ea;
    act_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 400) begin
      cnt++;
      if (inj && cnt == 5) begin
        start = 1'b1; pc_in = pc + 24'h100; ea_in = ea + 24'h10;
        mode = ~md; size = (sz == 2'd2) ? 2'd0 : 2'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    nbus = 0; nidle = 0;
    for (int i = 0; i < exp_n; i++) if (exp_k[i] == 2) nidle++; else nbus++;
    exp_clk = nbus * (4 + w) + nidle * 2;
    if (inj)
      check(cnt == exp_clk, "R11 clocks with start while busy", cnt, exp_clk);
    else if (w != 0)
      check(cnt == exp_clk, "R7 clocks with wait states", cnt, exp_clk);
    else begin
      check(cnt == exp_clk, "R9 total clocks", cnt, exp_clk);
      check(exp_clk == table_clocks(sz, md), "R9 clock table", exp_clk, table_clocks(sz, md));
    end
    check(act_n == exp_n, "R3/R5/R6 slot count", act_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < 16; i++) begin
      if (bad < 0 && (act_k[i] != exp_k[i] || (exp_k[i] != 2 && act_a[i] != exp_a[i])))
        bad = i;
    end
    if (bad >= 0)
      check(1'b0, "R2/R4/R6 slot order", int'(act_a[bad]) * 4 + act_k[bad],
            int'(exp_a[bad]) * 4 + exp_k[bad]);
    else
      check(1'b1, "R2/R4/R6 slot order", 0, 0);
    @(negedge clk);
    check(!done, "R10 done single clock", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_strobe && !idle && !done, "R12 reset outputs", int'({bus_strobe, idle, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_strobe && !idle && !done, "R12 after reset release",
          int'({bus_strobe, idle, done}), 0);
    // R1 sweep of all sizes and modes
    for (int s = 0; s < 3; s++)
      for (int m = 0; m < 8; m++)
        run_case(2'(s), 3'(m), 0, 1'b0);
    // R7 wait states
    run_case(2'd2, 3'd7, 1, 1'b0);
    run_case(2'd0, 3'd5, 3, 1'b0);
    run_case(2'd2, 3'd0, 2, 1'b0);
    // R11 start while busy
    run_case(2'd2, 3'd3, 0, 1'b1);
    run_case(2'd1, 3'd0, 0, 1'b1);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule